// File: doc/BRIEF.md
# Register Array To Reordering Shift Register

This block keeps a small register file of four 16-bit words. Each word is stored as two 8-bit byte registers. Next to the file sits a 16-bit shift register. A load strobe copies one chosen word into the shift register in a single clock. The copy is a parallel transfer. On the way, the word can be placed in one of three ways, picked by a two-bit order code:

- as it is;
- with its two bytes exchanged, while the bits inside each byte keep their order;
- fully mirrored, so both the byte order and the bit order inside each byte are reversed.

After a load, the shift register streams the word out one bit per shift enable, most significant bit first. A separate write port fills the rows one per clock. The block suits serializing a stored word toward a link whose bit or byte order differs from the storage order.

Top module: `regarray_shift_loader`

## Requirements
- R1: While reset is asserted, and after it is released, all four rows and the shift register hold zero, and `ser_out` reads 0.
- R2: When `wr_en` is high at a rising edge, row `wr_addr` takes `wr_data`. Rows that are not addressed keep their contents, and no row changes while `wr_en` is low.
- R3: Order code 2'b00 loads the selected row into the shift register unchanged. Bit i of the register equals bit i of the row.
- R4: Order code 2'b01 exchanges the bytes. Register bits [15:8] take row bits [7:0], and register bits [7:0] take row bits [15:8], with bit order inside each byte kept.
- R5: Order code 2'b10 loads the 16-bit mirror of the row. Register bit i equals row bit 15-i.
- R6: Order code 2'b11 behaves exactly as 2'b00.
- R7: If a write and a load name the same row at the same edge, the shift register receives that row's contents from before the write.
- R8: Each edge with `sh_en` high and `ld_en` low shifts the register left by one and puts 0 in bit 0. `ser_out` always shows register bit 15.
- R9: When `ld_en` and `sh_en` are both high at an edge, the load happens and no shift is applied.
- R10: With `ld_en` and `sh_en` both low, the shift register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Row write strobe |
| wr_addr | input | 2 | Row written when `wr_en` is high |
| wr_data | input | 16 | Word written to the row |
| ld_en | input | 1 | Parallel load strobe into the shift register |
| ld_row | input | 2 | Row selected as load source |
| order_mode | input | 2 | Placement code: 00 keep, 01 byte swap, 10 mirror, 11 keep |
| sh_en | input | 1 | Shift-left enable |
| ser_out | output | 1 | Most significant bit of the shift register |

## Verification
A wrong placement or a stale row value becomes visible on `ser_out` right after the load edge, but only in bit 15. A wrong bit at position k of the loaded word shows up only after 15-k further shifts. For this reason, every load in the bench is followed by a full run of sixteen shifts, plus one more shift that must read the zero fill. A corrupted row stays invisible at the ports until that row is loaded. The bench therefore loads every row in every order code after each batch of writes.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  localparam int BYTE_W = 8;
  localparam int BYTES  = 2;
  localparam int WORD_W = BYTE_W * BYTES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    ORD_KEEP   = 2'b00,
    ORD_SWAP   = 2'b01,
    ORD_MIRROR = 2'b10,
    ORD_SPARE  = 2'b11
  } order_e;

  // Reverse the order of the bytes in a word; bits inside each byte stay put.
  function automatic word_t swap_bytes(word_t w);
    word_t r;
    for (int b = 0; b < BYTES; b++)
      r[b*BYTE_W +: BYTE_W] = w[(BYTES-1-b)*BYTE_W +: BYTE_W];
    return r;
  endfunction

  // Reverse the bits inside a single byte.
  function automatic byte_t mirror_byte(byte_t v);
    byte_t r;
    for (int i = 0; i < BYTE_W; i++)
      r[i] = v[BYTE_W-1-i];
    return r;
  endfunction

  // Reverse the bits inside every byte of a word, keeping byte positions.
  function automatic word_t mirror_in_bytes(word_t w);
    word_t r;
    for (int b = 0; b < BYTES; b++)
      r[b*BYTE_W +: BYTE_W] = mirror_byte(w[b*BYTE_W +: BYTE_W]);
    return r;
  endfunction

  // Placement applied on the load path.
  function automatic word_t place_word(word_t w, order_e m);
    case (m)
      ORD_SWAP:   return swap_bytes(w);
      ORD_MIRROR: return mirror_in_bytes(swap_bytes(w));
      default:    return w;
    endcase
  endfunction
endpackage

// File: rtl/rsl_byte_reg.sv
module rsl_byte_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/rsl_row_array.sv
module rsl_row_array
  import rsl_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int ADDR_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output word_t             rd_word
);
  word_t row_q [ROWS];
  logic [ROWS-1:0] row_wr;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_wr[r] = wr_en && (wr_addr == ADDR_W'(r));
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      rsl_byte_reg #(.W(BYTE_W)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (row_wr[r]),
        .d     (wr_data[b*BYTE_W +: BYTE_W]),
        .q     (row_q[r][b*BYTE_W +: BYTE_W])
      );
    end

    // R2
    row_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_wr[r] |=> row_q[r] == $past(wr_data))
      else $error("row %0d write not captured", r);

    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !row_wr[r] |=> $stable(row_q[r]))
      else $error("row %0d changed without a write", r);
  end

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_wr))
    else $error("more than one row write strobe");

  assign rd_word = row_q[rd_addr];
endmodule

// File: rtl/rsl_order_place.sv
module rsl_order_place
  import rsl_pkg::*;
(
  input  word_t      src,
  input  logic [1:0] mode,
  output word_t      placed
);
  order_e mode_e;
  assign mode_e = order_e'(mode);
  assign placed = place_word(src, mode_e);
endmodule

// File: rtl/rsl_shifter.sv
module rsl_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_word,
  input  logic         sh,
  output logic         ser_out
);
  logic [W-1:0] q;
  logic         do_shift;

  assign do_shift = sh && !ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (ld)       q <= ld_word;
    else if (do_shift) q <= {q[W-2:0], 1'b0};
  end

  assign ser_out = q[W-1];

  // R8
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift |=> q == {$past(q[W-2:0]), 1'b0})
    else $error("shift step wrong");

  // R9
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(ld_word))
    else $error("load not taken");

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !sh) |=> $stable(q))
    else $error("register moved while idle");
endmodule

// File: rtl/regarray_shift_loader.sv
module regarray_shift_loader
  import rsl_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  localparam int ROW_AW  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_AW-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              ld_en,
  input  logic [ROW_AW-1:0] ld_row,
  input  logic [1:0]        order_mode,
  input  logic              sh_en,
  output logic              ser_out
);
  word_t rd_word;
  word_t placed;

  rsl_row_array #(.ROWS(NUM_ROWS), .ADDR_W(ROW_AW)) u_rows (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (ld_row),
    .rd_word (rd_word)
  );

  rsl_order_place u_place (
    .src    (rd_word),
    .mode   (order_mode),
    .placed (placed)
  );

  rsl_shifter #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ld_en),
    .ld_word (placed),
    .sh      (sh_en),
    .ser_out (ser_out)
  );

  // R3
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_mode == 2'b00) |-> placed == rd_word)
    else $error("keep placement wrong");

  // R4
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_mode == 2'b01) |->
      (placed[15:8] == rd_word[7:0]) && (placed[7:0] == rd_word[15:8]))
    else $error("byte swap placement wrong");

  // R5
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_mode == 2'b10) |-> placed == {<<{rd_word}})
    else $error("mirror placement wrong");

  // R6
  spare_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_mode == 2'b11) |-> placed == rd_word)
    else $error("spare code not treated as keep");
endmodule

// File: tb/tb_regarray_shift_loader.sv
`timescale 1ns/100ps
module tb_regarray_shift_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic ld_en = 1'b0;
  logic [1:0] ld_row = '0;
  logic [1:0] order_mode = '0;
  logic sh_en = 1'b0;
  logic ser_out;

  int checks = 0;
  int fails = 0;
  int mem_m [4];
  int sreg_m = 0;
  string tag_force = "";

  always #2.5 clk = ~clk;

  regarray_shift_loader dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ld_en(ld_en), .ld_row(ld_row),
    .order_mode(order_mode), .sh_en(sh_en), .ser_out(ser_out)
  );

  function automatic int arrange(int w, int md);
    int r = 0;
    for (int i = 0; i < 16; i++) begin
      int src;
      if (md == 1)      src = (i + 8) % 16;
      else if (md == 2) src = 15 - i;
      else              src = i;
      if ((w >> src) & 1) r = r | (1 << i);
    end
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: ser_out=%0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit we, int wa, int wd, bit ld, int lr, int md, bit sh);
    int nxt;
    string tag;
    @(negedge clk);
    wr_en = we; wr_addr = 2'(wa); wr_data = 16'(wd);
    ld_en = ld; ld_row = 2'(lr); order_mode = 2'(md); sh_en = sh;
    if (ld)      nxt = arrange(mem_m[lr], md);
    else if (sh) nxt = (sreg_m << 1) & 16'hFFFF;
    else         nxt = sreg_m;
    if (ld && we && wa == lr) tag = "R7";
    else if (ld && sh)        tag = "R9";
    else if (ld)              tag = (md == 1) ? "R4" : (md == 2) ? "R5" : (md == 3) ? "R6" : "R3";
    else if (sh)              tag = "R8";
    else                      tag = "R10";
    if (tag_force != "") tag = tag_force;
    @(posedge clk);
    #1;
    if (we) mem_m[wa] = wd & 16'hFFFF;
    sreg_m = nxt;
    check(tag, int'(ser_out), (sreg_m >> 15) & 1);
  endtask

  task automatic drain();
    for (int k = 0; k < 17; k++) step(0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mem_m[i] = 0;
    repeat (3) @(posedge clk);
    #1 check("R1", int'(ser_out), 0);
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1", int'(ser_out), 0);
    // R1: rows are zero after reset
    tag_force = "R1";
    for (int r = 0; r < 4; r++) begin
      step(0, 0, 0, 1, r, 2, 0);
      drain();
    end
    tag_force = "";

    // R2: fill rows, then read each back
    step(1, 0, 16'hA5C3, 0, 0, 0, 0);
    step(1, 1, 16'h1234, 0, 0, 0, 0);
    step(1, 2, 16'h8001, 0, 0, 0, 0);
    step(1, 3, 16'hF00F, 0, 0, 0, 0);
    tag_force = "R2";
    for (int r = 0; r < 4; r++) begin
      step(0, 0, 0, 1, r, 0, 0);
      drain();
    end
    tag_force = "";

    // R3 R4 R5 R6: every row in every order code
    for (int md = 0; md < 4; md++)
      for (int r = 0; r < 4; r++) begin
        step(0, 0, 0, 1, r, md, 0);
        drain();
      end

    // R7: write and load the same row together
    step(1, 1, 16'h0F0F, 1, 1, 0, 0);
    drain();
    step(0, 0, 0, 1, 1, 0, 0);
    drain();

    // R9: load wins over shift
    step(0, 0, 0, 1, 0, 1, 0);
    step(0, 0, 0, 1, 3, 2, 1);
    drain();

    // R10: idle cycles hold value
    step(0, 0, 0, 1, 2, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 0, 0);
    drain();

    for (int k = 0; k < 600; k++)
      step($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 16'hFFFF),
           ($urandom_range(0, 3) == 0), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 1));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule